// File: doc/BRIEF.md
# Write-Once Timer Rate Control with Free-Running Counter

This block holds the rate control for a free-running timer and contains the timer itself. One byte-wide control register carries four interrupt-enable bits in its upper nibble and a two-bit rate select in its lowest two bits. The enable bits can be written at any time. In normal operation the rate select can be set only once, and only during a short window of bus cycles that opens at reset. After the first accepted rate write, or once the window has run out, the rate stays fixed until the next reset. A test-mode input lifts both limits.

The chosen rate divides the bus clock to produce a count enable. The count enable advances a counter that wraps to zero and flags each wrap for one cycle. Software programs the rate early in its start-up code and then leaves it alone. Later writes can still change the enable bits, and the rate select is left as it was.

Top module: `tmr_rate_lock`

## Requirements
- R1: While reset is held, and on its release, `rdData` reads 0x00, `ieBits` reads 0, `cntValue` reads 0 and `ovfPulse` is low.
- R2: `rdData` is laid out as bits 7..4 = enables, bits 3..2 = always 0 whatever is written to them, bits 1..0 = rate select.
- R3: Every write loads `wrData[7:4]` into the enable bits, in any mode and at any time, including after the rate is locked. `ieBits` always equals `rdData[7:4]`.
- R4: The rate select divides the bus clock: 0 gives ÷1, 1 gives ÷4, 2 gives ÷8 and 3 gives ÷16. `cntValue` rises by exactly N/div over any N cycles when N is a multiple of div.
- R5: With `testMode` low, the first write on any of clock edges 1 through 64 after reset release loads `wrData[1:0]` into the rate select.
- R6: With `testMode` low, once one rate write has been accepted, later writes leave the rate select unchanged, even inside the window.
- R7: With `testMode` low, a write on edge 65 or later after reset release leaves the rate select unchanged, even if no rate write was ever made.
- R8: With `testMode` high, every write loads the rate select, at any time and any number of times.
- R9: After 0xFFFF the counter steps to 0x0000. `ovfPulse` is high for exactly the one cycle in which the counter shows the wrapped value.
- R10: `tickEn` is high on exactly one cycle in every div cycles, and the counter moves only on such cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| testMode | input | 1 | High lifts the window and write-once limits on the rate select |
| wrEn | input | 1 | Register write strobe, one per cycle |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Current register contents |
| ieBits | output | 4 | Enable bits, passed to interrupt logic |
| tickEn | output | 1 | Timer count enable from the divider |
| cntValue | output | 16 | Free-running counter value |
| ovfPulse | output | 1 | One-cycle flag on counter wrap |

## Verification
Two events can fall on the same clock edge. A write can land on the last edge of the protection window, on the same edge where the window counter reaches its end. A write after lock also changes the enable bits while the rate select is being refused. The bench steps the write edge across edges 1, 32, 63, 64, 65, 66 and 100. It then judges the rate select field and the enable field separately in the readback. The rate under each setting is judged by counting counter steps and `tickEn` pulses over a span that every divisor fits into evenly.

// File: rtl/trg_pkg.sv
package trg_pkg;
  localparam int RATE_W = 2;
  localparam int DIV_W  = 5;

  typedef struct packed {
    logic              rateLoad;
    logic [RATE_W-1:0] rateSel;
  } ctlStrobe_t;

  function automatic logic [DIV_W-1:0] divFor(input logic [RATE_W-1:0] sel);
    logic [DIV_W-1:0] d;
    case (sel)
      2'd0:    d = DIV_W'(1);
      2'd1:    d = DIV_W'(4);
      2'd2:    d = DIV_W'(8);
      default: d = DIV_W'(16);
    endcase
    return d;
  endfunction
endpackage

// File: rtl/trg_ctrl.sv
module trg_ctrl
  import trg_pkg::*;
#(
  parameter int WINDOW = 64,
  parameter int IE_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              testMode,
  input  logic              wrEn,
  input  logic [IE_W-1:0]   wrIe,
  input  logic [RATE_W-1:0] wrRate,
  output logic [IE_W-1:0]   ieReg,
  output logic [RATE_W-1:0] rateReg,
  output ctlStrobe_t        ctl
);
  localparam int WIN_W = $clog2(WINDOW + 1);
  localparam logic [WIN_W-1:0] WIN_END = WIN_W'(WINDOW);

  logic [WIN_W-1:0] winCnt;
  logic             rateDone;
  logic             winOpen;
  logic             rateOk;

  assign winOpen = (winCnt < WIN_END);
  assign rateOk  = wrEn && (testMode || (!rateDone && winOpen));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winCnt   <= '0;
      rateDone <= 1'b0;
      ieReg    <= '0;
      rateReg  <= '0;
    end else begin
      if (winOpen) winCnt <= winCnt + 1'b1;
      if (wrEn) ieReg <= wrIe;
      if (rateOk) begin
        rateReg <= wrRate;
        if (!testMode) rateDone <= 1'b1;
      end
    end
  end

  always_comb begin
    ctl          = '0;
    ctl.rateLoad = rateOk;
    ctl.rateSel  = rateReg;
  end
endmodule

// File: rtl/trg_dpath.sv
module trg_dpath
  import trg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       ctl,
  output logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLim;
  logic             atTop;

  assign divLim = divFor(ctl.rateSel) - 1'b1;
  assign tick   = (divCnt == divLim);
  assign atTop  = (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (ctl.rateLoad || tick) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      ovf <= tick && atTop;
      if (tick) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_rate_lock.sv
module tmr_rate_lock
  import trg_pkg::*;
#(
  parameter int WINDOW = 64,
  parameter int CNT_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             testMode,
  input  logic             wrEn,
  input  logic [7:0]       wrData,
  output logic [7:0]       rdData,
  output logic [3:0]       ieBits,
  output logic             tickEn,
  output logic [CNT_W-1:0] cntValue,
  output logic             ovfPulse
);
  ctlStrobe_t        ctl;
  logic [3:0]        ieReg;
  logic [RATE_W-1:0] rateReg;
  logic              unusedWr;

  assign unusedWr = ^wrData[3:2];

  trg_ctrl #(.WINDOW(WINDOW), .IE_W(4)) u_ctrl (
    .clk(clk), .rstN(rstN), .testMode(testMode), .wrEn(wrEn),
    .wrIe(wrData[7:4]), .wrRate(wrData[1:0]),
    .ieReg(ieReg), .rateReg(rateReg), .ctl(ctl)
  );

  trg_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .tick(tickEn), .cnt(cntValue), .ovf(ovfPulse)
  );

  assign rdData = {ieReg, 2'b00, rateReg};
  assign ieBits = ieReg;
endmodule

// File: rtl/tmr_rate_lock_chk.sv
module tmr_rate_lock_chk #(
  parameter int WINDOW = 64,
  parameter int CNT_W  = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             testMode,
  input logic             wrEn,
  input logic [7:0]       wrData,
  input logic [7:0]       rdData,
  input logic [3:0]       ieBits,
  input logic             tickEn,
  input logic [CNT_W-1:0] cntValue,
  input logic             ovfPulse
);
  int   seenCycles;
  logic seenRate;
  logic mayLoad;

  assign mayLoad = !seenRate && (seenCycles < WINDOW);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenCycles <= 0;
      seenRate   <= 1'b0;
    end else begin
      if (seenCycles < WINDOW) seenCycles <= seenCycles + 1;
      if (wrEn && !testMode && mayLoad) seenRate <= 1'b1;
    end
  end

  // R2
  zero_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdData[3:2] == 2'b00);

  // R3
  ie_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (rdData[7:4] == $past(wrData[7:4])) && (ieBits == rdData[7:4]));

  // R5
  rate_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !testMode && mayLoad) |=> rdData[1:0] == $past(wrData[1:0]));

  // R6
  rate_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !testMode && !mayLoad) |=> rdData[1:0] == $past(rdData[1:0]));

  // R8
  test_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && testMode) |=> rdData[1:0] == $past(wrData[1:0]));

  // R9
  ovf_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |-> cntValue == '0);

  // R9
  ovf_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |=> !ovfPulse);

  // R10
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(cntValue));

  // R10
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && cntValue != {CNT_W{1'b1}}) |=> cntValue == $past(cntValue) + 1'b1);
endmodule

bind tmr_rate_lock tmr_rate_lock_chk #(.WINDOW(WINDOW), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tmr_rate_lock_tb.sv
module tmr_rate_lock_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        testMode = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic [3:0]  ieBits;
  logic        tickEn;
  logic [15:0] cntValue;
  logic        ovfPulse;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  tmr_rate_lock u_dut (
    .clk(clk), .rstN(rstN), .testMode(testMode), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .ieBits(ieBits), .tickEn(tickEn),
    .cntValue(cntValue), .ovfPulse(ovfPulse)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected under 190000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // hold reset, release on a falling edge; next rising edge is edge 1
  task automatic doReset(input logic tm);
    @(negedge clk);
    rstN = 1'b0; wrEn = 1'b0; testMode = tm;
    repeat (3) @(negedge clk);
    #1;
    check(rdData == 8'h00, "R1 rdData", rdData, 0);
    check(cntValue == 16'h0 && !ovfPulse, "R1 counter", cntValue, 0);
    rstN = 1'b1;
  endtask

  // wait k falling edges, then place a write that lands on edge k+1
  task automatic writeAfter(input int k, input logic [7:0] d);
    repeat (k) @(negedge clk);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    #1;
  endtask

  task automatic measureRate(input int div, input string tag);
    int c0;
    int ticks;
    ticks = 0;
    @(negedge clk); #1;
    c0 = cntValue;
    for (int i = 0; i < 160; i++) begin
      if (tickEn) ticks++;
      @(negedge clk); #1;
    end
    check(((cntValue - c0) & 16'hFFFF) == 160 / div, {tag, " R4 count"}, (cntValue - c0) & 16'hFFFF, 160 / div);
    check(ticks == 160 / div, {tag, " R10 ticks"}, ticks, 160 / div);
  endtask

  initial begin
    int edgeList [7];
    int divs [4];
    edgeList = '{1, 32, 63, 64, 65, 66, 100};
    divs = '{1, 4, 8, 16};

    // R1 reset state
    doReset(1'b0);
    #1;
    check(ieBits == 4'h0, "R1 ieBits", ieBits, 0);

    // R4 / R2 / R10 sweep of every rate select
    for (int s = 0; s < 4; s++) begin
      doReset(1'b0);
      writeAfter(0, {4'hA, 2'b11, 2'(s)});
      check(rdData == {4'hA, 2'b00, 2'(s)}, "R2 R5 readback", rdData, {4'hA, 2'b00, 2'(s)});
      measureRate(divs[s], "rate");
    end

    // R5 / R7 window edge sweep
    foreach (edgeList[i]) begin
      doReset(1'b0);
      writeAfter(edgeList[i] - 1, 8'h52);
      check(rdData[1:0] == ((edgeList[i] <= 64) ? 2'd2 : 2'd0),
            (edgeList[i] <= 64) ? "R5 window accept" : "R7 window closed",
            rdData[1:0], (edgeList[i] <= 64) ? 2 : 0);
      check(rdData[7:4] == 4'h5, "R3 enables in window sweep", rdData[7:4], 5);
    end

    // R6 write-once inside the window
    doReset(1'b0);
    writeAfter(0, 8'h11);
    writeAfter(8, 8'hC3);
    check(rdData[1:0] == 2'd1, "R6 second write", rdData[1:0], 1);
    check(ieBits == 4'hC, "R3 enables after lock", ieBits, 12);
    measureRate(4, "locked");

    // R3 enables after window expiry, rate held at reset value
    doReset(1'b0);
    writeAfter(99, 8'hF3);
    check(rdData == 8'hF0, "R3 R7 late write", rdData, 8'hF0);

    // R8 test mode: repeated late writes
    doReset(1'b1);
    writeAfter(199, 8'h03);
    check(rdData[1:0] == 2'd3, "R8 late write", rdData[1:0], 3);
    writeAfter(3, 8'h01);
    check(rdData[1:0] == 2'd1, "R8 rewrite", rdData[1:0], 1);
    measureRate(4, "R8 test");

    // R9 wrap at divide by one
    doReset(1'b0);
    repeat (65535) @(negedge clk);
    #1;
    check(cntValue == 16'hFFFF && !ovfPulse, "R9 top", cntValue, 16'hFFFF);
    @(negedge clk); #1;
    check(cntValue == 16'h0000, "R9 wrap value", cntValue, 0);
    check(ovfPulse, "R9 pulse high", ovfPulse, 1);
    @(negedge clk); #1;
    check(cntValue == 16'h0001 && !ovfPulse, "R9 pulse single", {cntValue, 15'h0, ovfPulse}, 32'h10000);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule